// File: doc/BRIEF.md
# DDR Read Capture-Point Trainer

This block sits on the host side of a double-data-rate serial memory link and picks the delay tap at which read data is sampled. Before the data of each read, the memory spends a short preamble sending a known 8-bit learning pattern on every active data lane. The pad logic delays each lane by several fixed amounts and hands the block one sampled bit per tap, per lane and per clock edge. The block compares each tap's samples with the expected pattern and marks the taps that pass. It then selects the tap in the centre of the widest passing window.

The chosen tap is held for the data phase of the read. A new choice is made during the preamble of every read. If no tap passes, an error flag is raised and the tap from the last good training stays in use. The pattern contains both settled transitions (001, 110) and short-pulse transitions (101, 010), so the passing window is bounded on each side by the relevant kind of edge.

Top module: `ddr_capture_trainer`

## Requirements
- R1: While rst_n is low, at a clock edge tap_sel becomes DEFAULT_TAP (4 at default parameters), and locked and train_err become 0.
- R2: The pattern is sent most significant bit first over four preamble beats. On beat k (k = 0..3), the rising-edge sample must equal pattern[7-2k] and the falling-edge sample must equal pattern[6-2k]. The pattern is an input, so any 8-bit value can be trained against.
- R3: A tap passes only if every active lane matches the expected bit on both edges in all four beats. A single wrong bit on one active lane, on either edge, fails that tap.
- R4: mode 2'b00 makes lane 0 active, 2'b01 makes lanes 0 and 1 active, and 2'b10 or 2'b11 make all four lanes active. The samples of inactive lanes have no effect on the result.
- R5: The selected tap is start + (len-1)/2 (rounded down) of the longest run of consecutive passing taps. When two runs are equally long, the run with the lowest tap index wins.
- R6: tap_sel, locked and train_err take their new values at the clock edge that ends the fourth preamble beat.
- R7: If no tap passes, train_err goes to 1, locked stays 0 and tap_sel keeps its previous value.
- R8: The first beat of a preamble clears locked and train_err at its closing edge. tap_sel does not change while training is in progress.
- R9: tap_sel changes only at a training result edge. It stays constant during the data phase, and preamble beats after the fourth are ignored.
- R10: A preamble that ends before its fourth beat produces no result: tap_sel stays unchanged, and locked and train_err stay 0.
- R11: locked and train_err are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preamble | input | 1 | High for each clock of the learning-pattern preamble |
| mode | input | 2 | Active lane count: 00 x1, 01 x2, 10/11 x4 |
| pattern | input | 8 | Expected learning pattern (for example 8'h34) |
| samp_rise | input | 32 | Rising-edge samples, bit tap*4+lane |
| samp_fall | input | 32 | Falling-edge samples, bit tap*4+lane |
| tap_sel | output | 3 | Selected capture tap |
| locked | output | 1 | Last training found a passing tap |
| train_err | output | 1 | Last training found no passing tap |

## Verification
Each result comes from a single register stage. The new tap and flags appear after the rising edge that closes the fourth preamble beat, and the bench reads them at the falling edge that follows. The clearing of locked and train_err is checked at the falling edge after the first beat. Each check samples on a falling edge, where the design's outputs are settled, never on the rising edge where they change. The hold checks, for the data phase, for extra beats and for a preamble cut short, look at the outputs again a few falling edges later.

// File: rtl/ddr_train_pkg.sv
// Package: shared constants and the lane-mode encoding for the capture trainer.
// Assumes the learning pattern is 8 bits sent two bits per clock.
package ddr_train_pkg;
    localparam int PAT_W = 8;
    localparam int BEATS = PAT_W / 2;

    typedef enum logic [1:0] {
        LANES_X1  = 2'b00,
        LANES_X2  = 2'b01,
        LANES_X4  = 2'b10,
        LANES_X4B = 2'b11
    } lane_mode_e;

    // Returns the set of lanes that take part in the comparison for a mode.
    function automatic logic [3:0] active_lanes(input logic [1:0] m);
        case (m)
            LANES_X1: active_lanes = 4'b0001;
            LANES_X2: active_lanes = 4'b0011;
            default:  active_lanes = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/tap_lane_cmp.sv
// Module: compares one tap's rising and falling samples across all lanes
// against the expected bits for the current beat.
// Assumes lane_en marks the lanes that count; the other lanes are masked off.
module tap_lane_cmp #(
    parameter int NLANE = 4
) (
    input  logic [NLANE-1:0] rise_bits,
    input  logic [NLANE-1:0] fall_bits,
    input  logic             exp_rise,
    input  logic             exp_fall,
    input  logic [NLANE-1:0] lane_en,
    output logic             mismatch
);
    // Flag any enabled lane that differs from the expected bit on either edge.
    always_comb begin
        mismatch = |(((rise_bits ^ {NLANE{exp_rise}}) |
                      (fall_bits ^ {NLANE{exp_fall}})) & lane_en);
    end
endmodule

// File: rtl/tap_window_pick.sv
// Module: finds the longest run of passing taps and returns its centre,
// rounded down. When runs tie, the run with the lowest index wins.
// Assumes pass has one bit per tap, with tap 0 in bit 0.
module tap_window_pick #(
    parameter int NTAP  = 8,
    parameter int TAP_W = $clog2(NTAP)
) (
    input  logic [NTAP-1:0]  pass,
    output logic             any_pass,
    output logic [TAP_W-1:0] centre
);
    // Scan the taps once, tracking the current run and the best run so far.
    always_comb begin
        int run_len;
        int run_start;
        int best_len;
        int best_start;
        run_len    = 0;
        run_start  = 0;
        best_len   = 0;
        best_start = 0;
        for (int t = 0; t < NTAP; t++) begin
            if (pass[t]) begin
                if (run_len == 0) run_start = t;
                run_len = run_len + 1;
                if (run_len > best_len) begin
                    best_len   = run_len;
                    best_start = run_start;
                end
            end else begin
                run_len = 0;
            end
        end
        any_pass = (best_len != 0);
        centre   = (best_len != 0) ? TAP_W'(best_start + (best_len - 1) / 2) : '0;
    end
endmodule

// File: rtl/ddr_capture_trainer.sv
// Module: top of the capture-point trainer. It counts preamble beats, builds
// up per-tap mismatches, and at the end of the fourth beat selects and holds
// a tap or flags an error.
// Assumes preamble is high for one clock per beat and pattern is stable
// during the preamble. Sample bit index = tap*NLANE + lane.
module ddr_capture_trainer #(
    parameter int NTAP        = 8,
    parameter int NLANE       = 4,
    parameter int DEFAULT_TAP = NTAP / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   preamble,
    input  logic [1:0]             mode,
    input  logic [7:0]             pattern,
    input  logic [NTAP*NLANE-1:0]  samp_rise,
    input  logic [NTAP*NLANE-1:0]  samp_fall,
    output logic [$clog2(NTAP)-1:0] tap_sel,
    output logic                   locked,
    output logic                   train_err
);
    import ddr_train_pkg::*;

    localparam int TAP_W = $clog2(NTAP);

    logic [2:0]       beat_cnt;
    logic [1:0]       beat;
    logic             first_beat;
    logic             last_beat;
    logic             training;
    logic             exp_rise;
    logic             exp_fall;
    logic [NLANE-1:0] lane_en;
    logic [NTAP-1:0]  fail_now;
    logic [NTAP-1:0]  fail_acc;
    logic [NTAP-1:0]  pass_vec;
    logic             any_pass;
    logic [TAP_W-1:0] centre;

    // Decode the beat position and the expected bits for this beat (MSB first).
    always_comb begin
        beat       = beat_cnt[1:0];
        training   = preamble && !beat_cnt[2];
        first_beat = training && (beat_cnt == 3'd0);
        last_beat  = training && (beat_cnt == 3'd3);
        exp_rise   = pattern[{~beat, 1'b1}];
        exp_fall   = pattern[{~beat, 1'b0}];
        lane_en    = NLANE'(active_lanes(mode));
        pass_vec   = ~(fail_acc | fail_now);
    end

    generate
        for (genvar t = 0; t < NTAP; t++) begin : g_tap
            tap_lane_cmp #(.NLANE(NLANE)) cmp_i (
                .rise_bits (samp_rise[t*NLANE +: NLANE]),
                .fall_bits (samp_fall[t*NLANE +: NLANE]),
                .exp_rise  (exp_rise),
                .exp_fall  (exp_fall),
                .lane_en   (lane_en),
                .mismatch  (fail_now[t])
            );
        end
    endgenerate

    tap_window_pick #(.NTAP(NTAP), .TAP_W(TAP_W)) pick_i (
        .pass     (pass_vec),
        .any_pass (any_pass),
        .centre   (centre)
    );

    // Count preamble beats, saturating after the fourth, and restart when preamble drops.
    always_ff @(posedge clk) begin
        if (!rst_n)            beat_cnt <= '0;
        else if (!preamble)    beat_cnt <= '0;
        else if (!beat_cnt[2]) beat_cnt <= beat_cnt + 3'd1;
    end

    // Build up the per-tap mismatch flags over the four training beats.
    always_ff @(posedge clk) begin
        if (!rst_n)          fail_acc <= '0;
        else if (first_beat) fail_acc <= fail_now;
        else if (training)   fail_acc <= fail_acc | fail_now;
    end

    // Clear the flags at the start of training, then hold or update the tap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_sel   <= TAP_W'(DEFAULT_TAP);
            locked    <= 1'b0;
            train_err <= 1'b0;
        end else if (first_beat) begin
            locked    <= 1'b0;
            train_err <= 1'b0;
        end else if (last_beat) begin
            if (any_pass) begin
                tap_sel <= centre;
                locked  <= 1'b1;
            end else begin
                train_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_capture_trainer_chk.sv
// Checker: temporal properties of the trainer outputs, bound to the top.
// Assumes beat_cnt is the top's preamble beat counter (3 bits).
module ddr_capture_trainer_chk #(
    parameter int TAP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             preamble,
    input logic [2:0]       beat_cnt,
    input logic [TAP_W-1:0] tap_sel,
    input logic             locked,
    input logic             train_err
);
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && train_err));

    assert_tap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(preamble && beat_cnt == 3'd3) |-> $stable(tap_sel));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (preamble && beat_cnt == 3'd0) |=> (!locked && !train_err));

    assert_err_keeps_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_err) |-> $stable(tap_sel));

    assert_lock_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(preamble && beat_cnt == 3'd3));
endmodule

bind ddr_capture_trainer ddr_capture_trainer_chk #(.TAP_W($clog2(NTAP))) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .preamble  (preamble),
    .beat_cnt  (beat_cnt),
    .tap_sel   (tap_sel),
    .locked    (locked),
    .train_err (train_err)
);

// File: tb/ddr_capture_trainer_tb.sv
// Bench: walks a table of training vectors, then runs directed cases for
// reset, data-phase hold, a preamble that is cut short and one that runs long.
module ddr_capture_trainer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        preamble;
    logic [1:0]  mode;
    logic [7:0]  pattern;
    logic [31:0] samp_rise;
    logic [31:0] samp_fall;
    logic [2:0]  tap_sel;
    logic        locked;
    logic        train_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    ddr_capture_trainer dut_i (
        .clk(clk), .rst_n(rst_n), .preamble(preamble), .mode(mode),
        .pattern(pattern), .samp_rise(samp_rise), .samp_fall(samp_fall),
        .tap_sel(tap_sel), .locked(locked), .train_err(train_err)
    );

    // mode, pattern, pass mask, corrupted lane, expected tap, expected lock
    typedef struct packed {
        logic [1:0] m;
        logic [7:0] pat;
        logic [7:0] mask;
        logic [1:0] badl;
        logic [2:0] etap;
        logic       elock;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'b10, 8'h34, 8'b0011_1100, 2'd0, 3'd3, 1'b1},
        '{2'b10, 8'h34, 8'b0111_1110, 2'd0, 3'd3, 1'b1},
        '{2'b11, 8'hA5, 8'b1110_0111, 2'd2, 3'd1, 1'b1},
        '{2'b01, 8'h34, 8'b1111_0000, 2'd3, 3'd3, 1'b1},
        '{2'b00, 8'hC3, 8'b1111_0000, 2'd0, 3'd5, 1'b1},
        '{2'b10, 8'h34, 8'b1000_0000, 2'd1, 3'd7, 1'b1},
        '{2'b10, 8'h34, 8'b0000_0000, 2'd0, 3'd7, 1'b0},
        '{2'b10, 8'h0F, 8'b1101_1011, 2'd1, 3'd0, 1'b1},
        '{2'b01, 8'h34, 8'b0001_1110, 2'd1, 3'd2, 1'b1},
        '{2'b10, 8'h34, 8'b0111_0000, 2'd3, 3'd5, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample bits for one edge of one beat. Inactive lanes carry the inverted bit.
    // A failing tap gets one flipped bit on lane badl at beat t%4 (rise for t<4, fall otherwise).
    function automatic logic [31:0] gen(input logic [1:0] m, input logic [7:0] p,
                                        input logic [7:0] mask, input int badl,
                                        input int k, input bit fall);
        logic [31:0] v;
        int act;
        act = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
        v = '0;
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < 4; l++) begin
                logic b;
                if (k < 4) b = fall ? p[6-2*k] : p[7-2*k];
                else       b = logic'((t + l + k) % 2) ^ fall;
                if (l >= act) b = ~b;
                if (!mask[t] && l == badl && k == t % 4 && fall == (t >= 4)) b = ~b;
                v[t*4+l] = b;
            end
        end
        return v;
    endfunction

    // Drive nbeats preamble beats on falling edges, then drop preamble.
    task automatic run_train(input logic [1:0] m, input logic [7:0] p,
                             input logic [7:0] mask, input int badl, input int nbeats);
        logic [2:0] prev_tap;
        prev_tap = tap_sel;
        mode     = m;
        pattern  = p;
        for (int k = 0; k < nbeats; k++) begin
            @(negedge clk);
            preamble  = 1'b1;
            samp_rise = gen(m, p, mask, badl, k, 1'b0);
            samp_fall = gen(m, p, mask, badl, k, 1'b1);
            if (k == 1) begin
                check("R8 locked cleared", int'(locked), 0);
                check("R8 err cleared", int'(train_err), 0);
                check("R8 tap held in training", int'(tap_sel), int'(prev_tap));
            end
        end
        @(negedge clk);
        preamble  = 1'b0;
        samp_rise = 32'hA5C3_5A3C;
        samp_fall = 32'h3C5A_C3A5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; preamble = 1'b0; mode = 2'b10; pattern = 8'h34;
        samp_rise = '0; samp_fall = '0;
        repeat (3) @(negedge clk);
        check("R1 reset tap", int'(tap_sel), 4);
        check("R1 reset locked", int'(locked), 0);
        check("R1 reset err", int'(train_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            run_train(VECS[i].m, VECS[i].pat, VECS[i].mask, int'(VECS[i].badl), 4);
            check("R5 R6 selected tap", int'(tap_sel), int'(VECS[i].etap));
            check("R3 R4 locked", int'(locked), int'(VECS[i].elock));
            check("R7 err flag", int'(train_err), int'(!VECS[i].elock));
            check("R11 exclusive", int'(locked && train_err), 0);
            repeat (3) @(negedge clk);
            check("R9 tap held in data phase", int'(tap_sel), int'(VECS[i].etap));
        end

        // R10: a two-beat preamble leaves tap 5 and both flags low.
        run_train(2'b10, 8'h34, 8'b0000_0011, 0, 2);
        repeat (2) @(negedge clk);
        check("R10 short preamble tap", int'(tap_sel), 5);
        check("R10 short preamble locked", int'(locked), 0);
        check("R10 short preamble err", int'(train_err), 0);

        // R9: a six-beat preamble with junk in beats 4-5 still resolves to tap 0.
        run_train(2'b10, 8'h34, 8'b0000_0011, 0, 6);
        check("R9 long preamble tap", int'(tap_sel), 0);
        check("R9 long preamble locked", int'(locked), 1);

        // R2: a lane swap of bit order (pattern 8'h2C against 8'h34 data) fails all taps.
        run_train(2'b10, 8'h34, 8'hFF, 0, 4);
        run_train(2'b00, 8'h2C, 8'hFF, 0, 0);
        check("R2 baseline tap", int'(tap_sel), 3);
        mode = 2'b10; pattern = 8'h2C;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            preamble  = 1'b1;
            samp_rise = gen(2'b10, 8'h34, 8'hFF, 0, k, 1'b0);
            samp_fall = gen(2'b10, 8'h34, 8'hFF, 0, k, 1'b1);
        end
        @(negedge clk);
        preamble = 1'b0;
        check("R2 wrong order rejected err", int'(train_err), 1);
        check("R7 tap kept after err", int'(tap_sel), 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule